// File: doc/BRIEF.md
# Interleaved Tile Address Generator

This block turns an image coordinate into the linear element offset of that element inside a tiled surface. The surface is cut into square tiles that sit one after another in raster order. Inside a tile the elements follow a bit-interleaved curve in which each x bit is XORed with the y bit of the same weight. There are two format classes. Plain pixel formats use 16x16 tiles. Block-compressed formats use tiles of 4x4 whole compressed blocks. The reordering only moves whole elements, so it serves any element format.

The block has two sources. A single lookup takes one x/y pair and returns its offset one cycle later. A streaming walker visits every coordinate of the padded image in raster order, x fastest, and emits one offset per cycle. Both sources share one registered output with a valid/ready handshake. Alongside the element index there is a byte offset, which is the element offset scaled by a power-of-two element size.

Top module: `tile_addr_gen`

## Requirements
- R1: For plain formats (`cfg_block_fmt`=0) a tile is 16x16 elements. The in-tile index, from bit 7 down to bit 0, is y3, x3^y3, y2, x2^y2, y1, x1^y1, y0, x0^y0, where x and y are the coordinate bits within the tile. The element offset is tile_number*256 + index.
- R2: For block formats (`cfg_block_fmt`=1) a tile is 4x4 blocks. The index is {y1, x1^y1, y0, x0^y0} in bits 3..0, and the element offset is tile_number*16 + index.
- R3: The tile number is tile_row*`cfg_tiles_w` + tile_col, where tile_col is x divided by the tile edge and tile_row is y divided by the tile edge.
- R4: A coordinate with x >= `cfg_tiles_w`*edge or y >= `cfg_tiles_h`*edge sets `o_err`=1 and forces `o_elem_ofs` to 0.
- R5: `o_byte_ofs` equals `o_elem_ofs` shifted left by `cfg_bpe_log2` (1, 2, 4 or 8 bytes per element). At 4 bytes per element, one 16x16 tile spans 1024 bytes.
- R6: A lookup is taken when `req_valid` and `req_ready` are both high. Its result appears with `o_valid` high after exactly one clock edge. `req_ready` is high when the walker is idle and the output register is empty or being drained.
- R7: A `walk_start` pulse while idle and with non-zero tile counts makes the walker emit every coordinate of the padded image in raster order, x fastest, one per accepted transfer. `o_last` is high only on the final coordinate, after which the walker goes idle.
- R8: While `o_valid` is high and `o_ready` is low, the output holds all of its fields unchanged.
- R9: After a synchronous active-low reset, `o_valid` is 0, `walk_busy` is 0 and `req_ready` is 1, even if the reset lands in the middle of a walk.
- R10: `walk_start` is ignored while a walk is in progress or when either tile count is zero. Lookups are not accepted (`req_ready`=0) while a walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_tiles_w | input | TW_W | Image width in tiles |
| cfg_tiles_h | input | TW_W | Image height in tiles |
| cfg_block_fmt | input | 1 | 0 = plain pixels (16x16 tile), 1 = compressed blocks (4x4 tile) |
| cfg_bpe_log2 | input | 2 | Log2 of bytes per element, used for the byte offset |
| req_valid | input | 1 | Single lookup request |
| req_ready | output | 1 | Lookup can be taken this cycle |
| req_x | input | TW_W+4 | Lookup x coordinate in elements |
| req_y | input | TW_W+4 | Lookup y coordinate in elements |
| walk_start | input | 1 | Pulse to begin a raster walk of the whole image |
| walk_busy | output | 1 | A walk is in progress |
| o_valid | output | 1 | Output holds a result |
| o_ready | input | 1 | Downstream accepts the result |
| o_elem_ofs | output | 2*TW_W+8 | Linear element offset |
| o_byte_ofs | output | 2*TW_W+11 | Byte offset |
| o_err | output | 1 | Coordinate lay outside the padded image |
| o_last | output | 1 | Final coordinate of a walk |

## Verification
The bench aims at the XOR pairing: coordinates such as (1,0), (0,1), (15,15) and (5,3) separate a design that drops the XOR, swaps the bits of a pair, or falls back to plain Morton order. Tile crossings at x=16 and y=17, and the far corner of the image, expose wrong tile strides or a row-major/column-major mix-up. For block formats the bench checks that coordinate bits 2 and 3 move to the tile number and do not leak into the index. Range checks at exactly the padded limit catch an off-by-one comparison. Walks under random back-pressure catch outputs that change while stalled, a dropped or repeated coordinate, an early or missing last flag, and a walker that restarts on a second start pulse.

// File: rtl/tile_addr_pkg.sv
// Shared types for the tiled address generator.
// Assumes: only the two format classes below exist.
package tile_addr_pkg;

    typedef enum logic {
        FMT_PLAIN = 1'b0,   // 16x16 element tiles
        FMT_BLOCK = 1'b1    // 4x4 compressed-block tiles
    } fmt_e;

    localparam int PLAIN_EDGE_LOG2 = 4;
    localparam int BLOCK_EDGE_LOG2 = 2;
    localparam int IDX_W           = 2 * PLAIN_EDGE_LOG2;

endpackage

// File: rtl/tile_swizzle.sv
// In-tile index: interleaves the low coordinate bits with each x bit XORed
// with its y partner. For block formats only the low two bit pairs count,
// and the upper index bits are held at zero.
// Assumes: x_in/y_in carry the coordinate bits inside the plain tile edge.
module tile_swizzle
    import tile_addr_pkg::*;
(
    input  fmt_e                       fmt,
    input  logic [PLAIN_EDGE_LOG2-1:0] x_in,
    input  logic [PLAIN_EDGE_LOG2-1:0] y_in,
    output logic [IDX_W-1:0]           idx
);

    // One bit pair per coordinate weight; the upper pairs exist only for plain tiles
    for (genvar i = 0; i < PLAIN_EDGE_LOG2; i++) begin : g_pair
        if (i < BLOCK_EDGE_LOG2) begin : g_always
            assign idx[2*i+1] = y_in[i];
            assign idx[2*i]   = x_in[i] ^ y_in[i];
        end else begin : g_plain_only
            assign idx[2*i+1] = (fmt == FMT_PLAIN) & y_in[i];
            assign idx[2*i]   = (fmt == FMT_PLAIN) & (x_in[i] ^ y_in[i]);
        end
    end

endmodule

// File: rtl/tile_offset_calc.sv
// Combinational offset: splits a coordinate into tile column/row and in-tile
// bits, numbers tiles in raster order and appends the swizzled in-tile index.
// Flags coordinates outside the padded image and forces their offset to 0.
// Assumes: clk/rst_n serve only the guarding assertions.
module tile_offset_calc
    import tile_addr_pkg::*;
#(
    parameter  int TW_W  = 8,
    localparam int CRD_W = TW_W + PLAIN_EDGE_LOG2,
    localparam int OFS_W = 2 * TW_W + IDX_W
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TW_W-1:0]  tiles_w,
    input  logic [TW_W-1:0]  tiles_h,
    input  fmt_e             fmt,
    input  logic [CRD_W-1:0] x,
    input  logic [CRD_W-1:0] y,
    output logic [OFS_W-1:0] elem_ofs,
    output logic             err
);

    localparam int LIM_W = CRD_W + 1;
    localparam int TL_W  = 2 * TW_W;

    logic [LIM_W-1:0] lim_x, lim_y;
    logic [TW_W-1:0]  tile_col, tile_row;
    logic [TL_W-1:0]  tile_num;
    logic [IDX_W-1:0] idx;

    tile_swizzle u_swz (
        .fmt  (fmt),
        .x_in (x[PLAIN_EDGE_LOG2-1:0]),
        .y_in (y[PLAIN_EDGE_LOG2-1:0]),
        .idx  (idx)
    );

    // Padded image limits in elements for the selected tile edge
    always_comb begin
        if (fmt == FMT_BLOCK) begin
            lim_x = LIM_W'(tiles_w) << BLOCK_EDGE_LOG2;
            lim_y = LIM_W'(tiles_h) << BLOCK_EDGE_LOG2;
        end else begin
            lim_x = LIM_W'(tiles_w) << PLAIN_EDGE_LOG2;
            lim_y = LIM_W'(tiles_h) << PLAIN_EDGE_LOG2;
        end
    end

    // Tile column and row are the coordinate bits above the tile edge
    always_comb begin
        if (fmt == FMT_BLOCK) begin
            tile_col = x[BLOCK_EDGE_LOG2 +: TW_W];
            tile_row = y[BLOCK_EDGE_LOG2 +: TW_W];
        end else begin
            tile_col = x[PLAIN_EDGE_LOG2 +: TW_W];
            tile_row = y[PLAIN_EDGE_LOG2 +: TW_W];
        end
    end

    // Raster tile number, range flag and final element offset
    always_comb begin
        tile_num = TL_W'(tile_row) * TL_W'(tiles_w) + TL_W'(tile_col);
        err      = (LIM_W'(x) >= lim_x) || (LIM_W'(y) >= lim_y);
        if (err)
            elem_ofs = '0;
        else if (fmt == FMT_BLOCK)
            elem_ofs = (OFS_W'(tile_num) << (2 * BLOCK_EDGE_LOG2)) | OFS_W'(idx);
        else
            elem_ofs = (OFS_W'(tile_num) << IDX_W) | OFS_W'(idx);
    end

    AST_BLOCK_IDX_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_BLOCK) |-> (idx[IDX_W-1:2*BLOCK_EDGE_LOG2] == '0)); // R2

    AST_TILE_IN_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
        !err |-> (tile_num < TL_W'(TL_W'(tiles_w) * TL_W'(tiles_h)))); // R3

endmodule

// File: rtl/raster_walker.sv
// Raster walker: on a start pulse it latches the image configuration and steps
// x then y over every element of the padded image, one step per advance.
// Assumes: the caller asserts advance only when it takes the current coordinate.
module raster_walker
    import tile_addr_pkg::*;
#(
    parameter  int TW_W  = 8,
    localparam int CRD_W = TW_W + PLAIN_EDGE_LOG2
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TW_W-1:0]  tiles_w,
    input  logic [TW_W-1:0]  tiles_h,
    input  fmt_e             fmt,
    input  logic [1:0]       bpe_log2,
    input  logic             advance,
    output logic             busy,
    output logic [CRD_W-1:0] x,
    output logic [CRD_W-1:0] y,
    output logic             last,
    output logic [TW_W-1:0]  lat_tiles_w,
    output logic [TW_W-1:0]  lat_tiles_h,
    output fmt_e             lat_fmt,
    output logic [1:0]       lat_bpe_log2
);

    logic [CRD_W-1:0] x_max, y_max;
    logic             x_end, y_end;

    // Last coordinate of each axis for the latched tile edge
    always_comb begin
        if (lat_fmt == FMT_BLOCK) begin
            x_max = (CRD_W'(lat_tiles_w) << BLOCK_EDGE_LOG2) - CRD_W'(1);
            y_max = (CRD_W'(lat_tiles_h) << BLOCK_EDGE_LOG2) - CRD_W'(1);
        end else begin
            x_max = (CRD_W'(lat_tiles_w) << PLAIN_EDGE_LOG2) - CRD_W'(1);
            y_max = (CRD_W'(lat_tiles_h) << PLAIN_EDGE_LOG2) - CRD_W'(1);
        end
        x_end = (x == x_max);
        y_end = (y == y_max);
        last  = busy && x_end && y_end;
    end

    // Start, step and stop of the walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy         <= 1'b0;
            x            <= '0;
            y            <= '0;
            lat_tiles_w  <= '0;
            lat_tiles_h  <= '0;
            lat_fmt      <= FMT_PLAIN;
            lat_bpe_log2 <= '0;
        end else if (!busy) begin
            if (start && (tiles_w != '0) && (tiles_h != '0)) begin
                busy         <= 1'b1;
                x            <= '0;
                y            <= '0;
                lat_tiles_w  <= tiles_w;
                lat_tiles_h  <= tiles_h;
                lat_fmt      <= fmt;
                lat_bpe_log2 <= bpe_log2;
            end
        end else if (advance) begin
            if (x_end) begin
                x <= '0;
                if (y_end)
                    busy <= 1'b0;
                else
                    y <= y + CRD_W'(1);
            end else begin
                x <= x + CRD_W'(1);
            end
        end
    end

    AST_WALK_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && advance && !last) |=> busy); // R7

    AST_WALK_STOPS_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && advance && last) |=> !busy); // R7

    AST_WALK_IN_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((x <= x_max) && (y <= y_max))); // R7

endmodule

// File: rtl/tile_addr_gen.sv
// Top of the tiled address generator. It picks the coordinate source (walker
// while busy, otherwise a single lookup), computes the offset and holds it in
// one output register under a valid/ready handshake, with byte scaling.
// Assumes: the cfg_* inputs are stable whenever a lookup is presented.
module tile_addr_gen
    import tile_addr_pkg::*;
#(
    parameter  int TW_W   = 8,
    localparam int CRD_W  = TW_W + PLAIN_EDGE_LOG2,
    localparam int OFS_W  = 2 * TW_W + IDX_W,
    localparam int BYTE_W = OFS_W + 3
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW_W-1:0]   cfg_tiles_w,
    input  logic [TW_W-1:0]   cfg_tiles_h,
    input  logic              cfg_block_fmt,
    input  logic [1:0]        cfg_bpe_log2,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CRD_W-1:0]  req_x,
    input  logic [CRD_W-1:0]  req_y,
    input  logic              walk_start,
    output logic              walk_busy,
    output logic              o_valid,
    input  logic              o_ready,
    output logic [OFS_W-1:0]  o_elem_ofs,
    output logic [BYTE_W-1:0] o_byte_ofs,
    output logic              o_err,
    output logic              o_last
);

    logic             slot_free, walk_adv, req_take, load;
    logic [CRD_W-1:0] wk_x, wk_y;
    logic             wk_last;
    logic [TW_W-1:0]  wk_tw, wk_th;
    fmt_e             wk_fmt;
    logic [1:0]       wk_bpe;

    logic [CRD_W-1:0] src_x, src_y;
    logic [TW_W-1:0]  src_tw, src_th;
    fmt_e             src_fmt;
    logic [1:0]       src_bpe;
    logic             src_last;

    logic [OFS_W-1:0] calc_ofs;
    logic             calc_err;
    logic [1:0]       bpe_q;

    raster_walker #(.TW_W(TW_W)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (walk_start),
        .tiles_w      (cfg_tiles_w),
        .tiles_h      (cfg_tiles_h),
        .fmt          (fmt_e'(cfg_block_fmt)),
        .bpe_log2     (cfg_bpe_log2),
        .advance      (walk_adv),
        .busy         (walk_busy),
        .x            (wk_x),
        .y            (wk_y),
        .last         (wk_last),
        .lat_tiles_w  (wk_tw),
        .lat_tiles_h  (wk_th),
        .lat_fmt      (wk_fmt),
        .lat_bpe_log2 (wk_bpe)
    );

    // Handshake: walker has priority, lookups only while idle
    always_comb begin
        slot_free = !o_valid || o_ready;
        walk_adv  = walk_busy && slot_free;
        req_ready = !walk_busy && slot_free;
        req_take  = req_valid && req_ready;
        load      = walk_adv || req_take;
    end

    // Source selection between walker and single lookup
    always_comb begin
        if (walk_busy) begin
            src_x    = wk_x;
            src_y    = wk_y;
            src_tw   = wk_tw;
            src_th   = wk_th;
            src_fmt  = wk_fmt;
            src_bpe  = wk_bpe;
            src_last = wk_last;
        end else begin
            src_x    = req_x;
            src_y    = req_y;
            src_tw   = cfg_tiles_w;
            src_th   = cfg_tiles_h;
            src_fmt  = fmt_e'(cfg_block_fmt);
            src_bpe  = cfg_bpe_log2;
            src_last = 1'b0;
        end
    end

    tile_offset_calc #(.TW_W(TW_W)) u_calc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tiles_w  (src_tw),
        .tiles_h  (src_th),
        .fmt      (src_fmt),
        .x        (src_x),
        .y        (src_y),
        .elem_ofs (calc_ofs),
        .err      (calc_err)
    );

    // Output register: loads on a take, clears once drained
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid    <= 1'b0;
            o_elem_ofs <= '0;
            o_err      <= 1'b0;
            o_last     <= 1'b0;
            bpe_q      <= '0;
        end else if (load) begin
            o_valid    <= 1'b1;
            o_elem_ofs <= calc_ofs;
            o_err      <= calc_err;
            o_last     <= src_last;
            bpe_q      <= src_bpe;
        end else if (o_ready) begin
            o_valid    <= 1'b0;
            o_last     <= 1'b0;
        end
    end

    // Byte offset scaled by the element size of the held result
    always_comb begin
        o_byte_ofs = BYTE_W'(o_elem_ofs) << bpe_q;
    end

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_elem_ofs) && $stable(o_err)
                                   && $stable(o_last) && $stable(o_byte_ofs))); // R8

    AST_ERR_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_err) |-> (o_elem_ofs == '0)); // R4

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        o_last |-> o_valid); // R7

    AST_NO_LOOKUP_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_busy && $past(walk_busy)) |-> !req_ready); // R10

endmodule

// File: tb/tile_addr_gen_tb.sv
module tile_addr_gen_tb_top;

    localparam int TW_W   = 8;
    localparam int CRD_W  = TW_W + 4;
    localparam int OFS_W  = 2 * TW_W + 8;
    localparam int BYTE_W = OFS_W + 3;

    typedef struct packed {
        logic        blk;
        logic [7:0]  tw;
        logic [7:0]  th;
        logic [11:0] x;
        logic [11:0] y;
        logic [1:0]  bpe;
        logic [23:0] elem;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    // Hand-worked lookup vectors: format, tiles w/h, x, y, bpe, offset, err, requirement
    localparam vec_t VECS [16] = '{
        '{1'b0, 8'd4, 8'd4, 12'd0,  12'd0,  2'd0, 24'd0,    1'b0, 4'd1}, // R1 origin
        '{1'b0, 8'd4, 8'd4, 12'd1,  12'd0,  2'd0, 24'd1,    1'b0, 4'd1}, // R1 x0 only
        '{1'b0, 8'd4, 8'd4, 12'd0,  12'd1,  2'd0, 24'd3,    1'b0, 4'd1}, // R1 y0 pairs with x0
        '{1'b0, 8'd4, 8'd4, 12'd15, 12'd15, 2'd0, 24'd170,  1'b0, 4'd1}, // R1 XOR cancels
        '{1'b0, 8'd4, 8'd4, 12'd5,  12'd3,  2'd0, 24'd30,   1'b0, 4'd1}, // R1 mixed
        '{1'b0, 8'd4, 8'd4, 12'd16, 12'd0,  2'd0, 24'd256,  1'b0, 4'd3}, // R3 next tile
        '{1'b0, 8'd4, 8'd4, 12'd20, 12'd17, 2'd0, 24'd1299, 1'b0, 4'd3}, // R3 tile 5
        '{1'b0, 8'd4, 8'd4, 12'd63, 12'd63, 2'd0, 24'd4010, 1'b0, 4'd3}, // R3 far corner
        '{1'b1, 8'd3, 8'd2, 12'd5,  12'd6,  2'd0, 24'd77,   1'b0, 4'd2}, // R2 tile 4
        '{1'b1, 8'd3, 8'd2, 12'd3,  12'd3,  2'd0, 24'd10,   1'b0, 4'd2}, // R2 in tile 0
        '{1'b1, 8'd3, 8'd2, 12'd11, 12'd7,  2'd0, 24'd90,   1'b0, 4'd2}, // R2 last block
        '{1'b0, 8'd4, 8'd4, 12'd64, 12'd0,  2'd0, 24'd0,    1'b1, 4'd4}, // R4 x at limit
        '{1'b0, 8'd4, 8'd4, 12'd0,  12'd64, 2'd0, 24'd0,    1'b1, 4'd4}, // R4 y at limit
        '{1'b1, 8'd3, 8'd2, 12'd12, 12'd0,  2'd0, 24'd0,    1'b1, 4'd4}, // R4 block limit
        '{1'b0, 8'd4, 8'd4, 12'd15, 12'd15, 2'd2, 24'd170,  1'b0, 4'd5}, // R5 4 bytes
        '{1'b0, 8'd4, 8'd4, 12'd20, 12'd17, 2'd3, 24'd1299, 1'b0, 4'd5}  // R5 8 bytes
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TW_W-1:0]   cfg_tiles_w = '0;
    logic [TW_W-1:0]   cfg_tiles_h = '0;
    logic              cfg_block_fmt = 1'b0;
    logic [1:0]        cfg_bpe_log2 = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [CRD_W-1:0]  req_x = '0;
    logic [CRD_W-1:0]  req_y = '0;
    logic              walk_start = 1'b0;
    logic              walk_busy;
    logic              o_valid;
    logic              o_ready = 1'b1;
    logic [OFS_W-1:0]  o_elem_ofs;
    logic [BYTE_W-1:0] o_byte_ofs;
    logic              o_err;
    logic              o_last;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] lfsr = 8'hA5;

    always #4 clk = ~clk;

    tile_addr_gen #(.TW_W(TW_W)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Bit-by-bit model of the tiled layout
    function automatic longint ref_ofs(input bit blk, input int tw, input int x, input int y);
        int     edge_log2 = blk ? 2 : 4;
        longint idx = 0;
        longint tile;
        for (int i = 0; i < edge_log2; i++) begin
            idx |= longint'((y >> i) & 1) << (2*i + 1);
            idx |= longint'(((x >> i) ^ (y >> i)) & 1) << (2*i);
        end
        tile = longint'(y >> edge_log2) * tw + (x >> edge_log2);
        return (tile << (2 * edge_log2)) + idx;
    endfunction

    task automatic lookup(input vec_t v);
        string tag = $sformatf("R%0d", v.req);
        @(negedge clk);
        cfg_block_fmt = v.blk;
        cfg_tiles_w   = v.tw;
        cfg_tiles_h   = v.th;
        cfg_bpe_log2  = v.bpe;
        req_x         = v.x;
        req_y         = v.y;
        req_valid     = 1'b1;
        o_ready       = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R6", "req_ready idle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(o_valid == 1'b1, "R6", "valid one cycle later", o_valid, 1);
        chk(o_err == v.err, tag, "err", o_err, v.err);
        chk(o_elem_ofs == v.elem, tag, "elem offset", o_elem_ofs, v.elem);
        chk(o_byte_ofs == (BYTE_W'(v.elem) << v.bpe), "R5", "byte offset",
            o_byte_ofs, longint'(v.elem) << v.bpe);
        if (!v.err)
            chk(o_elem_ofs == ref_ofs(v.blk, v.tw, v.x, v.y), tag, "vs model",
                o_elem_ofs, ref_ofs(v.blk, v.tw, v.x, v.y));
    endtask

    // Walk the whole image, optionally with back-pressure and a second start (R10)
    task automatic run_walk(input bit blk, input int tw, input int th,
                            input bit backpress, input bit inject);
        int edge_len = blk ? 4 : 16;
        int wspan = tw * edge_len;
        int total = wspan * th * edge_len;
        int ex = 0, ey = 0, n = 0, guard = 0;
        bit hold = 1'b0, injected = 1'b0;
        longint h_ofs = 0;
        logic h_last = 1'b0;
        @(negedge clk);
        cfg_block_fmt = blk;
        cfg_tiles_w   = TW_W'(tw);
        cfg_tiles_h   = TW_W'(th);
        cfg_bpe_log2  = 2'd0;
        walk_start    = 1'b1;
        @(negedge clk);
        walk_start = 1'b0;
        chk(walk_busy == 1'b1, "R7", "busy after start", walk_busy, 1);
        while (n < total && guard < 20000) begin
            guard++;
            walk_start = 1'b0;
            req_valid  = 1'b0;
            if (hold) begin
                chk(o_valid && o_elem_ofs == h_ofs && o_last == h_last, "R8",
                    "held while stalled", o_elem_ofs, h_ofs);
                hold = 1'b0;
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            o_ready = backpress ? lfsr[0] : 1'b1;
            if (inject && !injected && n == 10) begin
                injected   = 1'b1;
                walk_start = 1'b1;
                req_valid  = 1'b1;
                #1;
                chk(req_ready == 1'b0, "R10", "no lookup during walk", req_ready, 0);
            end
            if (o_valid && o_ready) begin
                chk(o_elem_ofs == ref_ofs(blk, tw, ex, ey) && !o_err, "R7",
                    $sformatf("walk offset at (%0d,%0d)", ex, ey),
                    o_elem_ofs, ref_ofs(blk, tw, ex, ey));
                chk(o_last == (n == total - 1), "R7", "last flag", o_last, n == total - 1);
                n++;
                ex++;
                if (ex == wspan) begin
                    ex = 0;
                    ey++;
                end
            end else if (o_valid) begin
                hold   = 1'b1;
                h_ofs  = o_elem_ofs;
                h_last = o_last;
            end
            @(negedge clk);
        end
        walk_start = 1'b0;
        req_valid  = 1'b0;
        o_ready    = 1'b1;
        chk(n == total, "R7", "coordinates emitted", n, total);
        repeat (3) @(negedge clk);
        chk(o_valid == 1'b0 && walk_busy == 1'b0, "R7", "idle after walk",
            o_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(o_valid == 1'b0, "R9", "valid after reset", o_valid, 0);
        chk(walk_busy == 1'b0, "R9", "busy after reset", walk_busy, 0);
        chk(req_ready == 1'b1, "R9", "ready after reset", req_ready, 1);

        foreach (VECS[i]) lookup(VECS[i]);

        // R10 zero tile count: start ignored
        @(negedge clk);
        cfg_tiles_w = '0;
        cfg_tiles_h = 8'd2;
        walk_start  = 1'b1;
        @(negedge clk);
        walk_start = 1'b0;
        repeat (2) @(negedge clk);
        chk(walk_busy == 1'b0 && o_valid == 1'b0, "R10", "zero width walk ignored",
            walk_busy, 0);

        run_walk(1'b0, 1, 1, 1'b1, 1'b0);   // R7 R8 plain walk under back-pressure
        run_walk(1'b1, 3, 2, 1'b0, 1'b1);   // R7 R10 block walk, second start ignored
        run_walk(1'b1, 2, 2, 1'b1, 1'b0);   // R8 block walk under back-pressure

        // R9 reset in the middle of a walk
        @(negedge clk);
        cfg_block_fmt = 1'b0;
        cfg_tiles_w   = 8'd2;
        cfg_tiles_h   = 8'd2;
        walk_start    = 1'b1;
        @(negedge clk);
        walk_start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(o_valid == 1'b0, "R9", "valid after mid-walk reset", o_valid, 0);
        chk(walk_busy == 1'b0, "R9", "busy after mid-walk reset", walk_busy, 0);
        chk(req_ready == 1'b1, "R9", "ready after mid-walk reset", req_ready, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule